// File: doc/BRIEF.md
# Virtualized Interrupt Pending Aggregator

This block keeps the hypervisor-level interrupt state of one hart. It combines that state into the pending view the hypervisor reads and into the pending and enable views a guest sees. Software-injected pending bits, one guest-external line chosen by a selector field, and platform lines aimed at the guest are ORed into the hypervisor pending view. The guest views take the three standard supervisor bits from that view, moved down by one bit position, but only where the delegation mask lets them through. A few extra locally injected interrupts are exposed to the guest through a per-bit exposure mask.

The block sits next to a hart's CSR file. The hart reaches it through a simple registered read/write port. It sends out two registered signals: a hypervisor-level take request, gated by the supervisor global enable, and a guest interrupt-present flag. All inputs are captured in one flop stage. A change on an input lines shows on the outputs and in read data after the second rising clock edge.

Top module: `virq_pend_agg`

## Requirements
- R1: The guest-external pending register (address 1) shows input line k-1 at bit k for k from 1 to GEILEN. The guest-external enable register (address 0) can be written only at bits GEILEN down to 1. Bit 0 and all bits above GEILEN read as zero in both registers.
- R2: Bit 12 of the hypervisor pending view (address 3) reads 1 exactly when the AND of the guest-external pending and enable registers is nonzero.
- R3: Bit 10 of the hypervisor pending view is the OR of three terms: the injected-pending register (address 2) bit 10, the guest-external pending bit indexed by the selector, and the platform guest external input. A selector value of 0 picks no line. The guest-external enables do not gate the selected bit.
- R4: Bit 6 of the hypervisor pending view is the OR of injected-pending bit 6 and the platform guest timer input.
- R5: Bit 2 of the hypervisor pending view is the same storage bit as injected-pending bit 2. The injected-pending register can be written at bits 2, 6, 10 and 13 to 12+NEXT. No other bit changes unless a write occurs.
- R6: A write to the hypervisor pending view changes only bit 2. Bits 12, 10 and 6 ignore it.
- R7: The selector (address 5, bits 5:0) holds values from 0 to GEILEN. A write of a larger value leaves the old value in place.
- R8: The registered take output is 1 when the registered supervisor global enable is 1 and the hypervisor pending view ANDed with the hypervisor enable register (address 4, bits 2, 6, 10, 12) is nonzero.
- R9: The delegation mask (address 6) can be written at bits 2, 6 and 10. Where bit 4k+2 is set, guest pending (address 8) and guest enable (address 9) bit 4k+1 read hypervisor pending and enable bit 4k+2. A write to guest enable bit 4k+1 goes to hypervisor enable bit 4k+2. A write to guest pending bit 1 goes to injected-pending bit 2.
- R10: Where a delegation bit is clear, the matching guest pending and enable bits read zero, and writes to them are ignored.
- R11: The exposure mask (address 7) can be written at bits 13 to 12+NEXT. Where a mask bit is set, the guest pending bit at the same position mirrors injected-pending and is writable through address 8. Where a mask bit is clear, the guest pending bit reads zero and ignores writes.
- R12: The registered guest interrupt output is 1 when guest pending ANDed with guest enable is nonzero.
- R13: After reset, all stored state, read data and outputs are zero.
- R14: Read data is registered and reflects the address presented at the previous rising edge. Addresses 10 to 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| csr_we_i | input | 1 | Write strobe |
| csr_addr_i | input | 4 | Register address |
| csr_wdata_i | input | DW | Write data |
| csr_rdata_o | output | DW | Registered read data |
| ge_lines_i | input | GEILEN | Guest-external pending lines from the interrupt controller |
| vs_ext_i | input | 1 | Platform external line aimed at the guest |
| vs_tmr_i | input | 1 | Platform timer line aimed at the guest |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| hs_take_o | output | 1 | Hypervisor-level interrupt take request |
| guest_irq_o | output | 1 | Guest has an enabled pending interrupt |

## Verification
The bench sets the selector to a pending line while every guest-external enable is zero. A design that gated the selected line with the enables would then lose the guest external pending bit. It also writes selector values above the limit and selector zero with all lines pending. A design that truncated instead of refusing, or that read bit 0, would show a wrong selector or a spurious external bit. Writes of all ones go to the hypervisor pending view and to guest views while delegation or exposure is clear. A design that let them through would change injected or enable storage, and reads of other addresses would show it. Random traffic then mixes delegation, exposure and line changes against a bench model.

// File: rtl/vipa_pkg.sv
package vipa_pkg;

  typedef enum logic [3:0] {
    A_GEIE  = 4'd0,
    A_GEIP  = 4'd1,
    A_VIP   = 4'd2,
    A_HIP   = 4'd3,
    A_HIE   = 4'd4,
    A_VSEL  = 4'd5,
    A_DELEG = 4'd6,
    A_VIEN  = 4'd7,
    A_GPEND = 4'd8,
    A_GEN   = 4'd9
  } csr_sel_e;

  localparam int B_SSI    = 2;
  localparam int B_STI    = 6;
  localparam int B_SEI    = 10;
  localparam int B_SGE    = 12;
  localparam int EXT_BASE = 13;
  localparam int SEL_W    = 6;
  localparam int NSTD     = 3;

  // hypervisor position of standard pair k; the guest position is one lower
  function automatic int hpos(input int k);
    return 2 + 4 * k;
  endfunction

endpackage

// File: rtl/vipa_ge_unit.sv
module vipa_ge_unit
  import vipa_pkg::*;
#(
  parameter int DW     = 64,
  parameter int GEILEN = 5,
  localparam int GEW   = (GEILEN > 0) ? GEILEN : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [GEW-1:0]   ge_lines_i,
  input  logic             geie_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  output logic [DW-1:0]    geip_o,
  output logic [DW-1:0]    geie_o,
  output logic [SEL_W-1:0] vsel_o,
  output logic             sgeip_o,
  output logic             sel_line_o
);

  function automatic logic [DW-1:0] mk_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 1; i <= GEILEN; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] GE_MASK = mk_mask();

  logic [DW-1:0]    geip_d, geip_q, geie_q;
  logic [SEL_W-1:0] vsel_q;

  always_comb begin
    geip_d = '0;
    for (int i = 1; i <= GEILEN; i++) geip_d[i] = ge_lines_i[i-1];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      geip_q <= '0;
      geie_q <= '0;
    end else begin
      geip_q <= geip_d;
      if (geie_we_i) geie_q <= wdata_i & GE_MASK;
    end
  end

  generate
    if (GEILEN == 0) begin : g_nosel
      assign vsel_q = '0;
    end else begin : g_sel
      always_ff @(posedge clk_i) begin
        if (rst_i) vsel_q <= '0;
        else if (sel_we_i && (int'(sel_wdata_i) <= GEILEN)) vsel_q <= sel_wdata_i;
      end

      p_vsel_range_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(vsel_q) <= GEILEN);

      p_vsel_keep_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_we_i && (int'(sel_wdata_i) > GEILEN)) |=> $stable(vsel_q));
    end
  endgenerate

  assign sel_line_o = (vsel_q != '0) && geip_q[vsel_q];
  assign sgeip_o    = |(geip_q & geie_q);
  assign geip_o     = geip_q;
  assign geie_o     = geie_q;
  assign vsel_o     = vsel_q;

  p_geip_low_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !geip_q[0] && !geie_q[0]);

endmodule

// File: rtl/vipa_hyp_regs.sv
module vipa_hyp_regs
  import vipa_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NEXT = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          we_i,
  input  csr_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] vip_o,
  output logic [DW-1:0] hie_o,
  output logic [DW-1:0] deleg_o,
  output logic [DW-1:0] vien_o
);

  function automatic logic [DW-1:0] std_mask(input logic with_sge);
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < NSTD; k++) m[hpos(k)] = 1'b1;
    if (with_sge) m[B_SGE] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] ext_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int e = 0; e < NEXT; e++) m[EXT_BASE+e] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] DELEG_MASK = std_mask(1'b0);
  localparam logic [DW-1:0] HIE_MASK   = std_mask(1'b1);
  localparam logic [DW-1:0] VIEN_MASK  = ext_mask();
  localparam logic [DW-1:0] VIP_MASK   = DELEG_MASK | VIEN_MASK;

  logic [DW-1:0] vip_q, hie_q, deleg_q, vien_q;
  logic [DW-1:0] vip_d, hie_d, deleg_d, vien_d;

  always_comb begin
    vip_d   = vip_q;
    hie_d   = hie_q;
    deleg_d = deleg_q;
    vien_d  = vien_q;
    if (we_i) begin
      case (sel_i)
        A_VIP:   vip_d = wdata_i & VIP_MASK;
        A_HIP:   vip_d[B_SSI] = wdata_i[B_SSI];
        A_HIE:   hie_d = wdata_i & HIE_MASK;
        A_DELEG: deleg_d = wdata_i & DELEG_MASK;
        A_VIEN:  vien_d = wdata_i & VIEN_MASK;
        A_GPEND: begin
          if (deleg_q[B_SSI]) vip_d[B_SSI] = wdata_i[B_SSI-1];
          vip_d = (vip_d & ~vien_q) | (wdata_i & vien_q);
        end
        A_GEN: begin
          for (int k = 0; k < NSTD; k++)
            if (deleg_q[hpos(k)]) hie_d[hpos(k)] = wdata_i[hpos(k)-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vip_q   <= '0;
      hie_q   <= '0;
      deleg_q <= '0;
      vien_q  <= '0;
    end else begin
      vip_q   <= vip_d;
      hie_q   <= hie_d;
      deleg_q <= deleg_d;
      vien_q  <= vien_d;
    end
  end

  assign vip_o   = vip_q;
  assign hie_o   = hie_q;
  assign deleg_o = deleg_q;
  assign vien_o  = vien_q;

  p_vip_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !we_i |=> $stable(vip_q));

  p_hie_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !we_i |=> $stable(hie_q));

  p_hip_write_only_ssi_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && sel_i == A_HIP) |=> (vip_q[B_STI] == $past(vip_q[B_STI]))
                                 && (vip_q[B_SEI] == $past(vip_q[B_SEI])));

endmodule

// File: rtl/vipa_guest_view.sv
module vipa_guest_view
  import vipa_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NEXT = 4
) (
  input  logic [NSTD-1:0] hip3_i,
  input  logic [NSTD-1:0] hie3_i,
  input  logic [NSTD-1:0] deleg3_i,
  input  logic [NEXT-1:0] vip_ext_i,
  input  logic [NEXT-1:0] vien_ext_i,
  output logic [DW-1:0]   gpend_o,
  output logic [DW-1:0]   gen_o
);

  always_comb begin
    gpend_o = '0;
    gen_o   = '0;
    for (int k = 0; k < NSTD; k++) begin
      gpend_o[hpos(k)-1] = deleg3_i[k] & hip3_i[k];
      gen_o[hpos(k)-1]   = deleg3_i[k] & hie3_i[k];
    end
    for (int e = 0; e < NEXT; e++)
      gpend_o[EXT_BASE+e] = vien_ext_i[e] & vip_ext_i[e];
  end

endmodule

// File: rtl/virq_pend_agg.sv
module virq_pend_agg
  import vipa_pkg::*;
#(
  parameter int DW     = 64,
  parameter int GEILEN = 5,
  parameter int NEXT   = 4,
  localparam int GEW   = (GEILEN > 0) ? GEILEN : 1
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           csr_we_i,
  input  logic [3:0]     csr_addr_i,
  input  logic [DW-1:0]  csr_wdata_i,
  output logic [DW-1:0]  csr_rdata_o,
  input  logic [GEW-1:0] ge_lines_i,
  input  logic           vs_ext_i,
  input  logic           vs_tmr_i,
  input  logic           s_gie_i,
  output logic           hs_take_o,
  output logic           guest_irq_o
);

  csr_sel_e sel;
  assign sel = csr_sel_e'(csr_addr_i);

  logic ext_q, tmr_q, gie_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ext_q <= 1'b0;
      tmr_q <= 1'b0;
      gie_q <= 1'b0;
    end else begin
      ext_q <= vs_ext_i;
      tmr_q <= vs_tmr_i;
      gie_q <= s_gie_i;
    end
  end

  logic [DW-1:0]    geip, geie, vip, hie, deleg, vien, hip, gpend, gen;
  logic [SEL_W-1:0] vsel;
  logic             sgeip, sel_line;

  vipa_ge_unit #(.DW(DW), .GEILEN(GEILEN)) u_ge (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ge_lines_i  (ge_lines_i),
    .geie_we_i   (csr_we_i && sel == A_GEIE),
    .wdata_i     (csr_wdata_i),
    .sel_we_i    (csr_we_i && sel == A_VSEL),
    .sel_wdata_i (csr_wdata_i[SEL_W-1:0]),
    .geip_o      (geip),
    .geie_o      (geie),
    .vsel_o      (vsel),
    .sgeip_o     (sgeip),
    .sel_line_o  (sel_line)
  );

  vipa_hyp_regs #(.DW(DW), .NEXT(NEXT)) u_hyp (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (csr_we_i),
    .sel_i   (sel),
    .wdata_i (csr_wdata_i),
    .vip_o   (vip),
    .hie_o   (hie),
    .deleg_o (deleg),
    .vien_o  (vien)
  );

  always_comb begin
    hip        = '0;
    hip[B_SSI] = vip[B_SSI];
    hip[B_STI] = vip[B_STI] | tmr_q;
    hip[B_SEI] = vip[B_SEI] | sel_line | ext_q;
    hip[B_SGE] = sgeip;
  end

  logic [NSTD-1:0] hip3, hie3, deleg3;
  genvar k;
  generate
    for (k = 0; k < NSTD; k++) begin : g_std
      assign hip3[k]   = hip[hpos(k)];
      assign hie3[k]   = hie[hpos(k)];
      assign deleg3[k] = deleg[hpos(k)];
    end
  endgenerate

  vipa_guest_view #(.DW(DW), .NEXT(NEXT)) u_gv (
    .hip3_i     (hip3),
    .hie3_i     (hie3),
    .deleg3_i   (deleg3),
    .vip_ext_i  (vip[EXT_BASE +: NEXT]),
    .vien_ext_i (vien[EXT_BASE +: NEXT]),
    .gpend_o    (gpend),
    .gen_o      (gen)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (sel)
      A_GEIE:  rd_mux = geie;
      A_GEIP:  rd_mux = geip;
      A_VIP:   rd_mux = vip;
      A_HIP:   rd_mux = hip;
      A_HIE:   rd_mux = hie;
      A_VSEL:  rd_mux = {{(DW-SEL_W){1'b0}}, vsel};
      A_DELEG: rd_mux = deleg;
      A_VIEN:  rd_mux = vien;
      A_GPEND: rd_mux = gpend;
      A_GEN:   rd_mux = gen;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      csr_rdata_o <= '0;
      hs_take_o   <= 1'b0;
      guest_irq_o <= 1'b0;
    end else begin
      csr_rdata_o <= rd_mux;
      hs_take_o   <= gie_q && (|(hip & hie));
      guest_irq_o <= |(gpend & gen);
    end
  end

  p_take_needs_gie_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !gie_q |=> !hs_take_o);

  p_guest_ssi_hidden_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !deleg[B_SSI] |-> !gpend[B_SSI-1] && !gen[B_SSI-1]);

  p_geie_bit0_read_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(csr_addr_i) == 4'd0) |-> !csr_rdata_o[0]);

  p_sel_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (vsel == '0) |-> !sel_line);

  p_guest_irq_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    (gen == '0) |=> !guest_irq_o);

endmodule

// File: tb/test_virq_pend_agg.sv
module test_virq_pend_agg;

  localparam int DW = 64;
  localparam int GL = 5;
  localparam int NX = 4;
  localparam logic [63:0] M_GE   = 64'h3E;
  localparam logic [63:0] M_STD  = 64'h444;
  localparam logic [63:0] M_HIE  = 64'h1444;
  localparam logic [63:0] M_EXT  = 64'h1E000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [GL-1:0] ge_in = '0;
  logic          pe = 1'b0, pt = 1'b0, gie = 1'b0;
  logic          take, girq;

  always #2 clk = ~clk;

  virq_pend_agg #(.DW(DW), .GEILEN(GL), .NEXT(NX)) i_virq_pend_agg (
    .clk_i(clk), .rst_i(rst), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .ge_lines_i(ge_in),
    .vs_ext_i(pe), .vs_tmr_i(pt), .s_gie_i(gie),
    .hs_take_o(take), .guest_irq_o(girq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_geie = '0, m_vip = '0, m_hie = '0, m_deleg = '0, m_vien = '0;
  logic [5:0]  m_vsel = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] f_geip();
    return {{(63-GL){1'b0}}, ge_in, 1'b0};
  endfunction

  function automatic logic [63:0] f_hip();
    logic [63:0] g, h;
    g = f_geip();
    h = '0;
    h[2]  = m_vip[2];
    h[6]  = m_vip[6] | pt;
    h[10] = m_vip[10] | ((m_vsel != 0) && g[m_vsel]) | pe;
    h[12] = |(g & m_geie);
    return h;
  endfunction

  function automatic logic [63:0] f_gpend();
    logic [63:0] h, r;
    h = f_hip();
    r = m_vien & m_vip & M_EXT;
    for (int k = 0; k < 3; k++) r[1+4*k] = m_deleg[2+4*k] & h[2+4*k];
    return r;
  endfunction

  function automatic logic [63:0] f_gen();
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 3; k++) r[1+4*k] = m_deleg[2+4*k] & m_hie[2+4*k];
    return r;
  endfunction

  function automatic logic [63:0] f_read(input int a);
    case (a)
      0: return m_geie;
      1: return f_geip();
      2: return m_vip;
      3: return f_hip();
      4: return m_hie;
      5: return {58'd0, m_vsel};
      6: return m_deleg;
      7: return m_vien;
      8: return f_gpend();
      9: return f_gen();
      default: return '0;
    endcase
  endfunction

  function automatic string f_tag(input int a);
    case (a)
      0, 1: return "R1";
      2: return "R5";
      3: return "R2 R3 R4";
      4: return "R8";
      5: return "R7";
      6: return "R9";
      7: return "R11";
      8: return "R9 R10 R11";
      9: return "R9 R10";
      default: return "R14";
    endcase
  endfunction

  task automatic wr(input int a, input logic [63:0] d);
    addr = 4'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    case (a)
      0: m_geie = d & M_GE;
      2: m_vip = d & (M_STD | M_EXT);
      3: m_vip[2] = d[2];
      4: m_hie = d & M_HIE;
      5: if (d[5:0] <= 6'(GL)) m_vsel = d[5:0];
      6: m_deleg = d & M_STD;
      7: m_vien = d & M_EXT;
      8: begin
        if (m_deleg[2]) m_vip[2] = d[1];
        m_vip = (m_vip & ~m_vien) | (d & m_vien);
      end
      9: for (int k = 0; k < 3; k++) if (m_deleg[2+4*k]) m_hie[2+4*k] = d[1+4*k];
      default: ;
    endcase
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    addr = 4'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic check_all();
    logic [63:0] d;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 12; a++) begin
      rd(a, d);
      chk(f_tag(a), d, f_read(a));
    end
    chk("R8", {63'd0, take}, {63'd0, gie && (|(f_hip() & m_hie))});
    chk("R12", {63'd0, girq}, {63'd0, |(f_gpend() & f_gen())});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    for (int a = 0; a < 10; a++) begin
      rd(a, d);
      chk("R13", d, 64'd0);
    end
    chk("R13", {63'd0, take}, 64'd0);

    // R1: bit 0 and bits above GEILEN of the enable ignore writes
    wr(0, '1);
    rd(0, d);
    chk("R1", d, 64'h3E);

    // R3: selected line reaches bit 10 with enables all zero
    wr(0, 64'd0);
    ge_in = 5'b00100;
    wr(5, 64'd3);
    check_all();
    rd(3, d);
    chk("R3", d & 64'h1400, 64'h0400);

    // R3: selector zero picks nothing
    ge_in = '1;
    wr(5, 64'd0);
    check_all();
    rd(3, d);
    chk("R3", d[10], 1'b0);

    // R7: illegal selector value is not retained
    wr(5, 64'd4);
    wr(5, 64'd7);
    rd(5, d);
    chk("R7", d, 64'd4);

    // R6: write of ones to the pending view touches only bit 2
    ge_in = '0;
    wr(5, 64'd0);
    wr(3, '1);
    check_all();
    rd(2, d);
    chk("R6", d, 64'h4);

    // R10: guest views ignore writes while delegation is clear
    wr(6, 64'd0);
    wr(4, 64'd0);
    wr(9, '1);
    wr(8, 64'd0);
    rd(4, d);
    chk("R10", d, 64'd0);
    rd(2, d);
    chk("R10", d, 64'h4);

    // R9: delegated guest enables land in hypervisor enables
    wr(6, M_STD);
    wr(9, 64'h222);
    rd(4, d);
    chk("R9", d, 64'h444);

    // R11: exposure mask gates extra bits
    wr(7, 64'h6000);
    wr(8, 64'h1E000);
    rd(2, d);
    chk("R11", d & M_EXT, 64'h6000);

    // R8: take blocked by global enable, then allowed
    gie = 1'b0;
    check_all();
    chk("R8", {63'd0, take}, 64'd0);
    gie = 1'b1;
    check_all();

    for (int it = 0; it < 300; it++) begin
      case ($urandom % 4)
        0: wr($urandom % 16, {$urandom, $urandom});
        1: begin
          ge_in = GL'($urandom);
          pe = 1'($urandom);
          pt = 1'($urandom);
          gie = 1'($urandom);
        end
        2: wr(5, 64'($urandom % 8));
        default: wr(6 + ($urandom % 4), {$urandom, $urandom});
      endcase
      check_all();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule